// File: doc/BRIEF.md
# Silent-Channel Flag Generator

This block watches a two-channel sample stream, one frame at a time, and drives one flag pin per channel. A channel's flag goes active once that channel has delivered nothing but all-zero samples for a long unbroken run of frames. It drops again on the first frame that carries a non-zero sample for that channel. Downstream logic uses the pins to mute an output stage or to signal silence to a host.

Control inputs set how the pins behave. One bit enables detection. One inverts the pin polarity. One makes both pins wait until both channels are silent. One doubles the run length. A bypass input suspends detection entirely. A soft-reset input forces both flags active while it is held low, and keeps them active for a few frames after it is released. A separate routing select replaces the zero flags with two externally generated full-scale indications.

Top module: `zd_flags`

## Requirements
- R1: After the hardware reset `rst_n` is released, with `det_en`=1, `soft_run`=1 and `pol_inv`=0, both pins are 0 until a threshold is reached.
- R2: With `long_mode`=0, a channel's zero flag becomes active on the frame strobe that completes 8192 consecutive zero samples of that channel, and is inactive after 8191. With `pol_inv`=0 an active flag drives its pin to 1.
- R3: With `long_mode`=1 the run needed is 16384 frames; 8192 or 16383 zero frames leave the flag inactive.
- R4: A frame strobe that carries a non-zero sample clears that channel's flag in the cycle after the strobe. A sample presented without a strobe has no effect.
- R5: With `pol_inv`=1 every pin level produced by the zero flags, the forced state or the routed inputs is inverted.
- R6: With `det_en`=0 and `alt_sel`=0, both pins are 0 whatever the data and polarity.
- R7: While `bypass`=1 (and `alt_sel`=0) both pins are 0, and the run counters are cleared, so detection restarts from zero afterwards.
- R8: While `soft_run`=0 (with `det_en`=1, `bypass`=0, `alt_sel`=0) both flags are forced active and the run counters are cleared.
- R9: After `soft_run` returns to 1, both flags stay forced active until 4 frame strobes have been taken, and follow the data from the cycle after the 4th strobe.
- R10: With `both_req`=1, both pins show the AND of the left and right zero flags.
- R11: With `alt_sel`=1 the left and right pins carry `fs_left` and `fs_right`, inverted when `pol_inv`=1, independent of `det_en`, `bypass` and the data.
- R12: Each run counter saturates at its maximum (32767 for 15 bits) instead of wrapping, so a flag stays active through an arbitrarily long zero run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| frame_stb | input | 1 | One-cycle strobe marking a valid frame |
| left_smp | input | 24 | Left channel sample |
| right_smp | input | 24 | Right channel sample |
| det_en | input | 1 | Zero detection enable |
| pol_inv | input | 1 | Invert pin polarity |
| both_req | input | 1 | Pins require both channels silent |
| long_mode | input | 1 | Double the required zero run |
| bypass | input | 1 | Suspend detection and clear counters |
| soft_run | input | 1 | Soft reset, active low |
| alt_sel | input | 1 | Route full-scale inputs to pins |
| fs_left | input | 1 | External left full-scale indication |
| fs_right | input | 1 | External right full-scale indication |
| flag_left | output | 1 | Left flag pin |
| flag_right | output | 1 | Right flag pin |

## Verification
The hardest condition to reach from the ports is the saturation boundary. The counter has to pass its 15-bit limit while the flag is already active, which takes more than 32767 consecutive zero strobes with nothing in between. The stimulus holds the strobe high for an unbroken zero run of 36384 frames in double-length mode. A wrapping counter would then sit below the threshold, so the pin would read back inactive. The post-release hold is also reached deliberately: the bench releases the soft reset with non-zero data and samples the pins after the 3rd and after the 4th strobe.

// File: rtl/zd_pkg.sv
package zd_pkg;

   localparam int unsigned NUM_CH = 2;

   // Which source currently owns a flag pin.
   typedef enum logic [2:0] {
      PIN_SRC_OFF   = 3'd0,
      PIN_SRC_FORCE = 3'd1,
      PIN_SRC_ZERO  = 3'd2,
      PIN_SRC_BOTH  = 3'd3,
      PIN_SRC_ALT   = 3'd4
   } pin_src_e;

   // Choose the pin source from the control bits, highest priority first.
   function automatic pin_src_e pick_src(input logic alt_sel,
                                         input logic det_en,
                                         input logic bypass,
                                         input logic forced,
                                         input logic both_req);
      pin_src_e s;
      if (alt_sel)                s = PIN_SRC_ALT;
      else if (!det_en || bypass) s = PIN_SRC_OFF;
      else if (forced)            s = PIN_SRC_FORCE;
      else if (both_req)          s = PIN_SRC_BOTH;
      else                        s = PIN_SRC_ZERO;
      return s;
   endfunction

endpackage

// File: rtl/zd_run_counter.sv
module zd_run_counter #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned CNT_W    = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                stb_i,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic [CNT_W-1:0]    thr_i,
   output logic                zero_o,
   output logic [CNT_W-1:0]    cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             smp_zero;

   assign smp_zero = (smp_i == '0);

   always_comb begin
      cnt_d = cnt_q;
      if (clr_i) begin
         cnt_d = '0;
      end else if (stb_i) begin
         if (!smp_zero)             cnt_d = '0;
         else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign zero_o = (cnt_q >= thr_i);
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/zd_hold_timer.sv
module zd_hold_timer #(
   parameter int unsigned HOLD_STROBES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_run_i,
   input  logic stb_i,
   output logic forced_o,
   output logic busy_o
);

   localparam int unsigned HW = $clog2(HOLD_STROBES + 1);
   localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_STROBES);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (!soft_run_i) begin
         hold_q <= HOLD_LOAD;
      end else if (stb_i && hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end
   end

   assign busy_o   = (hold_q != '0);
   assign forced_o = !soft_run_i || busy_o;

endmodule

// File: rtl/zd_pin_mux.sv
module zd_pin_mux
   import zd_pkg::*;
#(
   parameter bit HAS_ALT = 1'b1
) (
   input  logic                alt_sel_i,
   input  logic                det_en_i,
   input  logic                bypass_i,
   input  logic                forced_i,
   input  logic                both_req_i,
   input  logic                pol_inv_i,
   input  logic [NUM_CH-1:0]   zero_i,
   input  logic [NUM_CH-1:0]   fs_i,
   output logic [NUM_CH-1:0]   pin_o
);

   logic     alt_eff;
   pin_src_e src;
   logic     both_zero;

   generate
      if (HAS_ALT) begin : g_alt
         assign alt_eff = alt_sel_i;
      end else begin : g_no_alt
         assign alt_eff = 1'b0;
      end
   endgenerate

   assign both_zero = &zero_i;
   assign src = pick_src(alt_eff, det_en_i, bypass_i, forced_i, both_req_i);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
      always_comb begin
         unique case (src)
            PIN_SRC_ALT:   pin_o[c] = fs_i[c] ^ pol_inv_i;
            PIN_SRC_OFF:   pin_o[c] = 1'b0;
            PIN_SRC_FORCE: pin_o[c] = ~pol_inv_i;
            PIN_SRC_BOTH:  pin_o[c] = both_zero ^ pol_inv_i;
            default:       pin_o[c] = zero_i[c] ^ pol_inv_i;
         endcase
      end
   end

endmodule

// File: rtl/zd_flags.sv
module zd_flags
   import zd_pkg::*;
#(
   parameter int unsigned SAMPLE_W     = 24,
   parameter int unsigned CNT_W        = 15,
   parameter int unsigned SHORT_RUN    = 8192,
   parameter int unsigned LONG_RUN     = 16384,
   parameter int unsigned HOLD_STROBES = 4,
   parameter bit          HAS_ALT      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_stb,
   input  logic [SAMPLE_W-1:0] left_smp,
   input  logic [SAMPLE_W-1:0] right_smp,
   input  logic                det_en,
   input  logic                pol_inv,
   input  logic                both_req,
   input  logic                long_mode,
   input  logic                bypass,
   input  logic                soft_run,
   input  logic                alt_sel,
   input  logic                fs_left,
   input  logic                fs_right,
   output logic                flag_left,
   output logic                flag_right
);

   localparam logic [CNT_W-1:0] THR_SHORT = CNT_W'(SHORT_RUN);
   localparam logic [CNT_W-1:0] THR_LONG  = CNT_W'(LONG_RUN);

   generate
      if (SHORT_RUN == 0 || SHORT_RUN >= (2 ** CNT_W))
         $error("SHORT_RUN must lie in 1 .. 2**CNT_W-1");
      if (LONG_RUN < SHORT_RUN || LONG_RUN >= (2 ** CNT_W))
         $error("LONG_RUN must lie in SHORT_RUN .. 2**CNT_W-1");
      if (HOLD_STROBES == 0)
         $error("HOLD_STROBES must be at least 1");
      if (SAMPLE_W == 0)
         $error("SAMPLE_W must be at least 1");
   endgenerate

   logic [CNT_W-1:0]    thr;
   logic                cnt_clr;
   logic                forced;
   logic                hold_busy;
   logic [SAMPLE_W-1:0] smp    [NUM_CH];
   logic [CNT_W-1:0]    cnt    [NUM_CH];
   logic [NUM_CH-1:0]   zero;
   logic [NUM_CH-1:0]   pins;
   logic [CNT_W-1:0]    cnt_left;
   logic [CNT_W-1:0]    cnt_right;

   assign thr     = long_mode ? THR_LONG : THR_SHORT;
   assign cnt_clr = bypass || !soft_run;
   assign smp[0]  = left_smp;
   assign smp[1]  = right_smp;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zd_run_counter #(
         .SAMPLE_W (SAMPLE_W),
         .CNT_W    (CNT_W)
      ) cnt_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_i  (cnt_clr),
         .stb_i  (frame_stb),
         .smp_i  (smp[c]),
         .thr_i  (thr),
         .zero_o (zero[c]),
         .cnt_o  (cnt[c])
      );
   end

   zd_hold_timer #(
      .HOLD_STROBES (HOLD_STROBES)
   ) hold_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_run_i (soft_run),
      .stb_i      (frame_stb),
      .forced_o   (forced),
      .busy_o     (hold_busy)
   );

   zd_pin_mux #(
      .HAS_ALT (HAS_ALT)
   ) mux_i (
      .alt_sel_i  (alt_sel),
      .det_en_i   (det_en),
      .bypass_i   (bypass),
      .forced_i   (forced),
      .both_req_i (both_req),
      .pol_inv_i  (pol_inv),
      .zero_i     (zero),
      .fs_i       ({fs_right, fs_left}),
      .pin_o      (pins)
   );

   assign cnt_left   = cnt[0];
   assign cnt_right  = cnt[1];
   assign flag_left  = pins[0];
   assign flag_right = pins[1];

endmodule

// File: rtl/zd_flags_chk.sv
module zd_flags_chk #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned CNT_W    = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_stb,
   input logic [SAMPLE_W-1:0] left_smp,
   input logic [SAMPLE_W-1:0] right_smp,
   input logic                det_en,
   input logic                pol_inv,
   input logic                both_req,
   input logic                bypass,
   input logic                soft_run,
   input logic                alt_sel,
   input logic                fs_left,
   input logic                fs_right,
   input logic                flag_left,
   input logic                flag_right,
   input logic [1:0]          zero,
   input logic                hold_busy,
   input logic [CNT_W-1:0]    cnt_left,
   input logic [CNT_W-1:0]    cnt_right
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic normal_path;
   assign normal_path = det_en && !bypass && !alt_sel;

   // R6: detection disabled keeps both pins low
   a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_en && !alt_sel) |-> (!flag_left && !flag_right));

   // R7: bypass clears both run counters
   a_r7_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (cnt_left == '0 && cnt_right == '0));

   // R8: soft reset forces the active level
   a_r8_soft_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (normal_path && !soft_run) |-> (flag_left == !pol_inv && flag_right == !pol_inv));

   // R9: release of soft reset starts the hold window
   a_r9_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_run) |-> hold_busy);

   // R4: non-zero strobe clears the channel flag
   a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && left_smp != '0) |=> !zero[0]);
   a_r4_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && right_smp != '0) |=> !zero[1]);

   // R2: a zero strobe advances the counter by one
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && left_smp == '0 && !bypass && soft_run && cnt_left != CNT_MAX)
      |=> cnt_left == CNT_W'($past(cnt_left) + 1'b1));

   // R12: saturated counter holds
   a_r12_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && right_smp == '0 && !bypass && soft_run && cnt_right == CNT_MAX)
      |=> cnt_right == CNT_MAX);

   // R10: combined mode drives equal pins
   a_r10_both_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (normal_path && both_req) |-> (flag_left == flag_right));

   // R11: routed full-scale inputs
   a_r11_alt_route: assert property (@(posedge clk) disable iff (!rst_n)
      alt_sel |-> (flag_left == (fs_left ^ pol_inv) && flag_right == (fs_right ^ pol_inv)));

endmodule

bind zd_flags zd_flags_chk #(
   .SAMPLE_W (SAMPLE_W),
   .CNT_W    (CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_stb  (frame_stb),
   .left_smp   (left_smp),
   .right_smp  (right_smp),
   .det_en     (det_en),
   .pol_inv    (pol_inv),
   .both_req   (both_req),
   .bypass     (bypass),
   .soft_run   (soft_run),
   .alt_sel    (alt_sel),
   .fs_left    (fs_left),
   .fs_right   (fs_right),
   .flag_left  (flag_left),
   .flag_right (flag_right),
   .zero       (zero),
   .hold_busy  (hold_busy),
   .cnt_left   (cnt_left),
   .cnt_right  (cnt_right)
);

// File: tb/zd_flags_tb_top.sv
module zd_flags_tb_top;

   localparam int SW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic [SW-1:0] left_smp = '0;
   logic [SW-1:0] right_smp = '0;
   logic det_en = 1'b1, pol_inv = 1'b0, both_req = 1'b0, long_mode = 1'b0;
   logic bypass = 1'b0, soft_run = 1'b1, alt_sel = 1'b0;
   logic fs_left = 1'b0, fs_right = 1'b0;
   logic flag_left, flag_right;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   zd_flags dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .left_smp(left_smp), .right_smp(right_smp),
      .det_en(det_en), .pol_inv(pol_inv), .both_req(both_req),
      .long_mode(long_mode), .bypass(bypass), .soft_run(soft_run),
      .alt_sel(alt_sel), .fs_left(fs_left), .fs_right(fs_right),
      .flag_left(flag_left), .flag_right(flag_right)
   );

   typedef struct packed {
      logic [3:0] req;
      logic en, pol, both, alt, byp, fsl, fsr, exl, exr;
   } vec_t;

   // Walked with left flag active, right inactive, no strobes.
   localparam vec_t VECS [11] = '{
      '{4'd2,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0}, // R2
      '{4'd5,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1}, // R5
      '{4'd10, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // R10
      '{4'd10, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1}, // R10 inverted
      '{4'd6,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // R6
      '{4'd6,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}, // R6 inverted
      '{4'd11, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0}, // R11
      '{4'd11, 1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1}, // R11 inverted, bypass ignored
      '{4'd11, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1}, // R11
      '{4'd7,  1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0}, // R7 bypass low
      '{4'd7,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0}  // R7 counters cleared
   };

   task automatic chk(input int req, input logic el, input logic er);
      n_checks++;
      if (flag_left !== el || flag_right !== er) begin
         n_fail++;
         $display("FAIL R%0d: pins L/R = %b%b, expected %b%b", req,
                  flag_left, flag_right, el, er);
      end
   endtask

   // n strobes with fixed samples; returns at a negedge with strobe low.
   task automatic run(input int n, input logic [SW-1:0] l, input logic [SW-1:0] r);
      @(negedge clk);
      frame_stb = 1'b1; left_smp = l; right_smp = r;
      repeat (n - 1) @(negedge clk);
      @(negedge clk);
      frame_stb = 1'b0;
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1 chk(1, 1'b0, 1'b0);                 // R1 reset state

      run(8191, 24'd0, 24'd3);
      chk(2, 1'b0, 1'b0);                    // R2 one short
      run(1, 24'd0, 24'd3);
      chk(2, 1'b1, 1'b0);                    // R2 threshold reached

      foreach (VECS[i]) begin
         @(negedge clk);
         det_en = VECS[i].en; pol_inv = VECS[i].pol; both_req = VECS[i].both;
         alt_sel = VECS[i].alt; bypass = VECS[i].byp;
         fs_left = VECS[i].fsl; fs_right = VECS[i].fsr;
         #1 chk(int'(VECS[i].req), VECS[i].exl, VECS[i].exr);
      end

      run(8192, 24'd0, 24'd0);
      chk(2, 1'b1, 1'b1);                    // R2 both channels
      run(1, 24'd5, 24'd0);
      chk(4, 1'b0, 1'b1);                    // R4 immediate clear
      @(negedge clk); left_smp = '0; right_smp = 24'd7;
      repeat (5) @(negedge clk);
      #1 chk(4, 1'b0, 1'b1);                 // R4 no strobe, no effect

      @(negedge clk) long_mode = 1'b1;
      run(1, 24'd1, 24'd1);
      run(8192, 24'd0, 24'd0);
      chk(3, 1'b0, 1'b0);                    // R3 short run not enough
      run(8191, 24'd0, 24'd0);
      chk(3, 1'b0, 1'b0);                    // R3 one short
      run(1, 24'd0, 24'd0);
      chk(3, 1'b1, 1'b1);                    // R3 threshold reached
      run(20000, 24'd0, 24'd0);
      chk(12, 1'b1, 1'b1);                   // R12 past counter limit

      @(negedge clk) long_mode = 1'b0; soft_run = 1'b0;
      left_smp = 24'd9; right_smp = 24'd9;
      #1 chk(8, 1'b1, 1'b1);                 // R8 forced active
      pol_inv = 1'b1;
      #1 chk(8, 1'b0, 1'b0);                 // R8 forced, inverted
      pol_inv = 1'b0;
      @(negedge clk) soft_run = 1'b1;
      #1 chk(9, 1'b1, 1'b1);                 // R9 held after release
      run(3, 24'd9, 24'd9);
      chk(9, 1'b1, 1'b1);                    // R9 still held after 3
      run(1, 24'd9, 24'd9);
      chk(9, 1'b0, 1'b0);                    // R9 released after 4

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule